// File: doc/BRIEF.md
# Negate and Complement Flag Unit

This unit carries out three single-operand operations on a byte, word or longword held in a 32-bit operand: two's-complement negation, negation that also subtracts the extend flag, and bitwise complement. It also produces the five condition flags for that operation: extend (X), negative (N), zero (Z), overflow (V) and carry (C). When the size is narrower than a longword, only the low bits are changed. The bits above the selected size pass through to the result unchanged.

The operation and flag logic is combinational. The result and the flags are captured on a rising clock edge only while the enable strobe is high. The surrounding execution stage supplies the operand and the current flags, pulses the enable, and reads the registered outputs on the next cycle. Negating with extend over several operands, from the low part upward, gives a multi-precision negation, and Z then reports whether the whole value is zero.

Top module: `negflag_unit`

## Requirements
- R1: Operation code 0 (negate) gives the sized result 0 minus the operand.
- R2: Operation code 1 (negate with extend) gives the sized result 0 minus the operand minus the X flag input.
- R3: Operation code 2 (complement) inverts every bit of the operand within the selected size.
- R4: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Result bits above the selected size equal the operand bits.
- R5: Operation code 3 (hold) returns the operand unchanged and copies the flag inputs to the flag outputs.
- R6: For negate, C is 1 exactly when the sized result is non-zero, Z is 1 exactly when it is zero, and X equals C.
- R7: For negate with extend, C is 1 when the sized operand is non-zero or X is 1, and X equals C. Z becomes 0 for a non-zero sized result and otherwise keeps its input value.
- R8: For both negate operations, V is 1 exactly when the sign bit of the sized operand and the sign bit of the sized result are both 1.
- R9: For every operation except hold, N is the most significant bit of the sized result.
- R10: For complement, V and C are 0, X keeps its input value, and Z is 1 exactly when the sized result is zero.
- R11: The outputs change only on a rising clock edge with the enable high. Otherwise they hold their values.
- R12: During reset, the result is zero and all flags are zero.
- Flag vectors are ordered X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Capture strobe for result and flags |
| operand | input | 32 | Source and destination operand |
| sizeSel | input | 2 | Operand size code |
| opSel | input | 2 | Operation code |
| flagsIn | input | 5 | Current flags {X,N,Z,V,C} |
| result | output | 32 | Registered result |
| flagsOut | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
The bench targets the points where the negate variants are easy to get wrong. It applies the most negative byte and longword, where a design that drops the overflow term would report V=0. It negates zero with X set, where a design that ignores the extend input would return zero and clear C. It negates a zero word with Z already set, where a design that recomputes Z instead of keeping it sticky would still set Z but would also set it from a cleared input. Complement with X, V and C preset shows whether X is wrongly overwritten or whether V and C fail to clear. Non-zero upper bytes and words check that narrow sizes leave the upper bits alone, and an idle enable shows whether the registers update when they must not.

// File: rtl/negflag_pkg.sv
package negflag_pkg;

  localparam int DATA_W    = 32;
  localparam int FLAG_W    = 5;
  localparam int NUM_SIZES = 3;

  localparam int FLAG_X = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [1:0] {
    OP_NEG  = 2'd0,
    OP_NEGX = 2'd1,
    OP_NOT  = 2'd2,
    OP_HOLD = 2'd3
  } opKind_t;

  typedef struct packed {
    logic                 subExtend;
    logic                 invert;
    logic                 hold;
    logic                 stickyZ;
    logic [NUM_SIZES-1:0] sizeHot;
  } ctrlStrobes_t;

endpackage

// File: rtl/negflag_ctrl.sv
module negflag_ctrl
  import negflag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   opSel,
  input  logic [1:0]   sizeSel,
  output ctrlStrobes_t strobes
);

  opKind_t opKind;

  always_comb begin
    opKind = opKind_t'(opSel);
    strobes = '0;
    unique case (opKind)
      OP_NEG:  strobes.subExtend = 1'b0;
      OP_NEGX: begin
        strobes.subExtend = 1'b1;
        strobes.stickyZ   = 1'b1;
      end
      OP_NOT:  strobes.invert = 1'b1;
      OP_HOLD: strobes.hold   = 1'b1;
      default: strobes.hold   = 1'b1;
    endcase
    unique case (sizeSel)
      2'd0:    strobes.sizeHot = 3'b001;
      2'd1:    strobes.sizeHot = 3'b010;
      default: strobes.sizeHot = 3'b100;
    endcase
  end

  // R4: exactly one size lane selected
  assert_one_size_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.sizeHot) == 1);

  // R5: operation strobes never overlap
  assert_op_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.subExtend, strobes.invert, strobes.hold}));

endmodule

// File: rtl/negflag_dp.sv
module negflag_dp
  import negflag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  operand,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  flagsOut
);

  logic [DATA_W:0]      negWide;
  logic                 extIn;
  logic [DATA_W-1:0]    rawRes;
  logic [DATA_W-1:0]    sizeMask;
  logic [DATA_W-1:0]    maskBySize [NUM_SIZES];
  logic [NUM_SIZES-1:0] resMsbLane;
  logic [NUM_SIZES-1:0] opMsbLane;
  logic [DATA_W-1:0]    sizedRes;
  logic [DATA_W-1:0]    nextResult;
  logic [FLAG_W-1:0]    nextFlags;
  logic                 resMsb;
  logic                 opMsb;
  logic                 resZero;
  logic                 opNonZero;
  logic                 carryOut;

  assign extIn   = strobes.subExtend & flagsIn[FLAG_X];
  assign negWide = {1'b0, {DATA_W{1'b0}}} - {1'b0, operand} - {{DATA_W{1'b0}}, extIn};

  always_comb begin
    if (strobes.hold)        rawRes = operand;
    else if (strobes.invert) rawRes = ~operand;
    else                     rawRes = negWide[DATA_W-1:0];
  end

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
    localparam int LANE_W = 8 << i;
    assign maskBySize[i] = strobes.sizeHot[i] ? DATA_W'((64'd1 << LANE_W) - 64'd1) : '0;
    assign resMsbLane[i] = strobes.sizeHot[i] & rawRes[LANE_W-1];
    assign opMsbLane[i]  = strobes.sizeHot[i] & operand[LANE_W-1];
  end

  always_comb begin
    sizeMask = '0;
    for (int i = 0; i < NUM_SIZES; i++) sizeMask = sizeMask | maskBySize[i];
  end

  assign sizedRes   = rawRes & sizeMask;
  assign nextResult = (operand & ~sizeMask) | sizedRes;
  assign resMsb     = |resMsbLane;
  assign opMsb      = |opMsbLane;
  assign resZero    = (sizedRes == '0);
  assign opNonZero  = |(operand & sizeMask);
  assign carryOut   = opNonZero | extIn;

  always_comb begin
    nextFlags = flagsIn;
    if (!strobes.hold) begin
      nextFlags[FLAG_N] = resMsb;
      if (strobes.invert) begin
        nextFlags[FLAG_X] = flagsIn[FLAG_X];
        nextFlags[FLAG_Z] = resZero;
        nextFlags[FLAG_V] = 1'b0;
        nextFlags[FLAG_C] = 1'b0;
      end else begin
        nextFlags[FLAG_C] = carryOut;
        nextFlags[FLAG_X] = carryOut;
        nextFlags[FLAG_V] = opMsb & resMsb;
        nextFlags[FLAG_Z] = strobes.stickyZ ? (resZero & flagsIn[FLAG_Z]) : resZero;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      flagsOut <= '0;
    end else if (enable) begin
      result   <= nextResult;
      flagsOut <= nextFlags;
    end
  end

  // R11: idle cycles leave outputs alone
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(result) && $stable(flagsOut)));

  // R6 / R7: negate variants copy C into X
  assert_x_follows_c_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strobes.hold && !strobes.invert) |=> (flagsOut[FLAG_X] == flagsOut[FLAG_C]));

  // R10: complement keeps X and clears V, C
  assert_not_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.invert) |=>
      (flagsOut[FLAG_X] == $past(flagsIn[FLAG_X]) && !flagsOut[FLAG_V] && !flagsOut[FLAG_C]));

  // R7: Z never set by negate with extend unless it was already set
  assert_sticky_z_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.stickyZ && !flagsIn[FLAG_Z]) |=> !flagsOut[FLAG_Z]);

  // R4: byte size leaves upper 24 bits untouched
  assert_upper_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.sizeHot[0]) |=> (result[DATA_W-1:8] == $past(operand[DATA_W-1:8])));

  // R5: hold passes operand and flags
  assert_hold_op_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strobes.hold) |=> (result == $past(operand) && flagsOut == $past(flagsIn)));

endmodule

// File: rtl/negflag_unit.sv
module negflag_unit
  import negflag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [31:0]       operand,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        opSel,
  input  logic [4:0]        flagsIn,
  output logic [31:0]       result,
  output logic [4:0]        flagsOut
);

  ctrlStrobes_t strobes;

  negflag_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opSel   (opSel),
    .sizeSel (sizeSel),
    .strobes (strobes)
  );

  negflag_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .strobes  (strobes),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

endmodule

// File: tb/negflag_unit_bench.sv
module negflag_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  opSel = '0;
  logic [4:0]  flagsIn = '0;
  logic [31:0] result;
  logic [4:0]  flagsOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  negflag_unit u_negflag_unit (
    .clk(clk), .rstN(rstN), .enable(enable), .operand(operand),
    .sizeSel(sizeSel), .opSel(opSel), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut)
  );

  // {op, size, flagsIn, operand, expResult, expFlags}; flags are XNZVC
  localparam int NUM_VEC = 14;
  localparam logic [77:0] VEC [NUM_VEC] = '{
    {2'd0, 2'd0, 5'b00000, 32'h000000E7, 32'h00000019, 5'b10001}, // R1 R6
    {2'd2, 2'd0, 5'b00000, 32'h000000E7, 32'h00000018, 5'b00000}, // R3
    {2'd0, 2'd0, 5'b00000, 32'h12345680, 32'h12345680, 5'b11011}, // R8 R4
    {2'd0, 2'd1, 5'b11111, 32'hAAAA0000, 32'hAAAA0000, 5'b00100}, // R6 R4
    {2'd0, 2'd2, 5'b00000, 32'h00000001, 32'hFFFFFFFF, 5'b11001}, // R9
    {2'd1, 2'd0, 5'b10100, 32'h00000000, 32'h000000FF, 5'b11001}, // R2 R7
    {2'd1, 2'd1, 5'b00100, 32'hFFFF0000, 32'hFFFF0000, 5'b00100}, // R7 sticky
    {2'd1, 2'd1, 5'b00000, 32'h00000000, 32'h00000000, 5'b00000}, // R7
    {2'd1, 2'd2, 5'b10000, 32'h7FFFFFFF, 32'h80000000, 5'b11001}, // R2 R8
    {2'd2, 2'd1, 5'b10011, 32'h1234FFFF, 32'h12340000, 5'b10100}, // R10 R4
    {2'd2, 2'd2, 5'b00000, 32'h0F0F0F0F, 32'hF0F0F0F0, 5'b01000}, // R9 R3
    {2'd3, 2'd0, 5'b01010, 32'hDEADBEEF, 32'hDEADBEEF, 5'b01010}, // R5
    {2'd0, 2'd3, 5'b00000, 32'h80000000, 32'h80000000, 5'b11011}, // R4 R8
    {2'd1, 2'd0, 5'b10000, 32'h00000080, 32'h0000007F, 5'b10001}  // R7 R8
  };

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyOp(input logic [1:0] op, input logic [1:0] sz,
                         input logic [4:0] fl, input logic [31:0] val);
    @(negedge clk);
    opSel = op; sizeSel = sz; flagsIn = fl; operand = val; enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R12 reset result", result, 32'h0);
    checkVal("R12 reset flags", {27'd0, flagsOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NUM_VEC; i++) begin
      applyOp(VEC[i][77:76], VEC[i][75:74], VEC[i][73:69], VEC[i][68:37]);
      checkVal($sformatf("R1-vector %0d result (R1/R2/R3/R4/R5)", i), result, VEC[i][36:5]);
      checkVal($sformatf("vector %0d flags (R6/R7/R8/R9/R10)", i), {27'd0, flagsOut}, {27'd0, VEC[i][4:0]});
    end

    // R11: with enable low, new inputs must not reach the outputs
    @(negedge clk);
    opSel = 2'd0; sizeSel = 2'd2; flagsIn = 5'b00000; operand = 32'h00000005; enable = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R11 idle result", result, 32'h0000007F);
    checkVal("R11 idle flags", {27'd0, flagsOut}, 32'h00000011);

    // R11: a single enable pulse then captures them
    applyOp(2'd0, 2'd2, 5'b00000, 32'h00000005);
    checkVal("R11 R1 captured result", result, 32'hFFFFFFFB);
    checkVal("R11 R6 captured flags", {27'd0, flagsOut}, 32'h00000019);

    // R12: reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R12 rerun reset result", result, 32'h0);
    checkVal("R12 rerun reset flags", {27'd0, flagsOut}, 32'h0);
    rstN = 1'b1;

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule